// File: doc/BRIEF.md
# Channel Change-of-Status Interrupt Unit

This unit watches a vector of per-channel alarm status bits and raises an interrupt whenever an enabled channel's alarm bit flips in either direction. Each channel has a mask bit in an enable register and a sticky flag in a pending register. Both registers sit on a small byte-wide register bus with an address, a write strobe, a read strobe and write and read data.

The alarm vector is sampled once into a register. A change is found by comparing that sample with the sample from the cycle before. A change on a channel whose enable bit is 1 sets that channel's pending flag. The flag stays set until software reads the pending register, which returns the flags and clears them in the same cycle. The single interrupt line is active high and is the OR of all pending flags. Software reads the pending register to learn which channels changed since its last read.

Top module: `chgirq_top`

## Requirements
- R1: After reset the enable register and the pending register are both 00h, the interrupt output is 0 and the read data output is 00h.
- R2: A write strobe with address 14h loads the write data into the enable register. A read of address 14h returns it. Bit n of every register belongs to channel n.
- R3: When the alarm bit of an enabled channel goes from 0 to 1, its pending bit is set. The interrupt output is 1 after the second rising clock edge that follows the new alarm value being applied, and not after the first.
- R4: When the alarm bit of an enabled channel goes from 1 to 0, its pending bit is also set.
- R5: A change on a channel whose enable bit is 0 sets no pending bit, and enabling the channel later does not record that change after the fact.
- R6: The interrupt output is active high. It is 1 exactly while at least one pending bit is 1.
- R7: A read strobe with address 15h returns the pending register on the read data output after that clock edge. At the same edge all pending bits clear, so an immediate second read returns 00h.
- R8: An enabled change detected in the same cycle as a pending-register read is not lost. The read returns the earlier flags, and afterwards the pending register holds only the new change.
- R9: Writes to address 15h and writes to any address other than 14h change no register. Reads of any address other than 14h and 15h return 00h.
- R10: Changes on several enabled channels in the same cycle each set their own pending bit.
- R11: The read data output holds the value of the last read until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alarm_i | input | 8 | Per-channel alarm status, one bit per channel |
| addr_i | input | 8 | Register address |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe, one cycle per read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt, active high, OR of pending bits |

## Verification
The hardest case to reach from the ports is a change that lands in the very cycle in which software reads the pending register, because the read strobe and the internal change pulse must coincide at one clock edge. The bench first sets an older flag on another channel. It then flips an alarm bit and raises the read strobe exactly one edge later, when the sampled value differs from its predecessor. It checks that the read returns only the older flag and that a second read returns only the new one. A similar timing check confirms that the interrupt is still low one edge after the alarm flip and high after the second.

// File: rtl/chgirq_pkg.sv
package chgirq_pkg;

    // Channel count; every register holds one bit per channel
    localparam int unsigned CHG_NCH = 8;
    // Register bus address width
    localparam int unsigned CHG_AW  = 8;

    // Offsets of the two registers
    localparam logic [CHG_AW-1:0] CHG_ADDR_MASK = 8'h14;
    localparam logic [CHG_AW-1:0] CHG_ADDR_PEND = 8'h15;

    // Register selector used by the bank decode
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_PEND = 2'd2
    } chg_sel_e;

endpackage

// File: rtl/chgirq_edge.sv
module chgirq_edge
    import chgirq_pkg::*;
#(
    parameter int unsigned NCH = CHG_NCH
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [NCH-1:0] alarm_i,
    output logic [NCH-1:0] chg_o
);

    typedef struct packed {
        logic [NCH-1:0] smp;
        logic [NCH-1:0] prev;
    } edge_state_t;

    edge_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.smp  = alarm_i;
        state_d.prev = state_q.smp;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // A flip in either direction counts as a change
    assign chg_o = state_q.smp ^ state_q.prev;

    // Alarm taken through exactly one register stage
    assert_single_sample_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (state_q.smp == $past(alarm_i)));

    // A change pulse is the difference between the last two samples
    assert_change_history_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(rst_ni, 2)) |->
            (chg_o == ($past(alarm_i) ^ $past(alarm_i, 2))));

endmodule

// File: rtl/chgirq_decode.sv
module chgirq_decode
    import chgirq_pkg::*;
#(
    parameter int unsigned       AW        = CHG_AW,
    parameter logic [AW-1:0]     MASK_ADDR = CHG_ADDR_MASK,
    parameter logic [AW-1:0]     PEND_ADDR = CHG_ADDR_PEND
) (
    input  logic [AW-1:0] addr_i,
    output chg_sel_e      sel_o
);

    always_comb begin
        if (addr_i == MASK_ADDR) begin
            sel_o = SEL_MASK;
        end else if (addr_i == PEND_ADDR) begin
            sel_o = SEL_PEND;
        end else begin
            sel_o = SEL_NONE;
        end
    end

endmodule

// File: rtl/chgirq_regs.sv
module chgirq_regs
    import chgirq_pkg::*;
#(
    parameter int unsigned NCH = CHG_NCH
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  chg_sel_e       sel_i,
    input  logic           wr_i,
    input  logic           rd_i,
    input  logic [NCH-1:0] wdata_i,
    input  logic [NCH-1:0] chg_i,
    output logic [NCH-1:0] rdata_o,
    output logic [NCH-1:0] pend_o
);

    typedef struct packed {
        logic [NCH-1:0] mask;
        logic [NCH-1:0] pend;
        logic [NCH-1:0] rdata;
    } bank_state_t;

    bank_state_t state_d, state_q;

    logic           mask_wr;
    logic           pend_rd;
    logic [NCH-1:0] hit;

    always_comb begin
        mask_wr = wr_i && (sel_i == SEL_MASK);
        pend_rd = rd_i && (sel_i == SEL_PEND);
        hit     = chg_i & state_q.mask;

        state_d = state_q;

        if (mask_wr) begin
            state_d.mask = wdata_i;
        end

        // A read clears older flags; a change at the same edge survives
        if (pend_rd) begin
            state_d.pend = hit;
        end else begin
            state_d.pend = state_q.pend | hit;
        end

        if (rd_i) begin
            unique case (sel_i)
                SEL_MASK: state_d.rdata = state_q.mask;
                SEL_PEND: state_d.rdata = state_q.pend;
                default:  state_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata_o = state_q.rdata;
    assign pend_o  = state_q.pend;

    // Mask register moves only on a decoded write
    assert_mask_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(wr_i && (sel_i == SEL_MASK)) |-> $stable(state_q.mask));

    // After a pending read only changes from that edge remain
    assert_clear_on_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rd_i && (sel_i == SEL_PEND)) |->
            ((state_q.pend & ~$past(chg_i & state_q.mask)) == '0));

    // Read data is stable without a read strobe
    assert_rdata_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(rd_i) |-> $stable(rdata_o));

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan_chk
        // A flag only rises from an enabled change
        assert_set_needs_enable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(state_q.pend[ch]) |-> $past(chg_i[ch] && state_q.mask[ch]));

        // A flag stays set until a pending read
        assert_flag_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(state_q.pend[ch]) && !$past(rd_i && (sel_i == SEL_PEND)))
                |-> state_q.pend[ch]);
    end

endmodule

// File: rtl/chgirq_top.sv
module chgirq_top
    import chgirq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CHG_NCH-1:0] alarm_i,
    input  logic [CHG_AW-1:0]  addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [CHG_NCH-1:0] wdata_i,
    output logic [CHG_NCH-1:0] rdata_o,
    output logic              irq_o
);

    logic [CHG_NCH-1:0] chg;
    logic [CHG_NCH-1:0] pend;
    chg_sel_e           sel;

    chgirq_edge #(
        .NCH (CHG_NCH)
    ) u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .alarm_i (alarm_i),
        .chg_o   (chg)
    );

    chgirq_decode #(
        .AW        (CHG_AW),
        .MASK_ADDR (CHG_ADDR_MASK),
        .PEND_ADDR (CHG_ADDR_PEND)
    ) u_decode (
        .addr_i (addr_i),
        .sel_o  (sel)
    );

    chgirq_regs #(
        .NCH (CHG_NCH)
    ) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sel_i   (sel),
        .wr_i    (wr_i),
        .rd_i    (rd_i),
        .wdata_i (wdata_i),
        .chg_i   (chg),
        .rdata_o (rdata_o),
        .pend_o  (pend)
    );

    assign irq_o = |pend;

    // Interrupt rises only after an edge that saw an enabled change
    assert_irq_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> $past(|chg));

endmodule

// File: tb/chgirq_top_test.sv
module chgirq_top_test;

    logic       clk;
    logic       rst_n;
    logic [7:0] alarm;
    logic [7:0] addr;
    logic       wr;
    logic       rd;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    localparam logic [7:0] A_MASK = 8'h14;
    localparam logic [7:0] A_PEND = 8'h15;

    chgirq_top uut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .alarm_i (alarm),
        .addr_i  (addr),
        .wr_i    (wr),
        .rd_i    (rd),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    initial clk = 0;
    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1;
        @(negedge clk);
        wr = 0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
        addr = a; rd = 1;
        @(negedge clk);
        rd = 0;
        d = rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 rdata", rdata, 8'h00);
        reg_read(A_MASK, v); check("R1 mask", v, 8'h00);
        reg_read(A_PEND, v); check("R1 pend", v, 8'h00);
    endtask

    task automatic t_mask_rw;
        logic [7:0] v;
        reg_write(A_MASK, 8'hA5);
        reg_read(A_MASK, v); check("R2 mask readback", v, 8'hA5);
    endtask

    task automatic t_ignored;
        logic [7:0] v;
        reg_write(A_PEND, 8'hFF);
        check("R9 irq after pend write", {7'd0, irq}, 8'h00);
        reg_read(A_PEND, v); check("R9 pend write ignored", v, 8'h00);
        reg_write(8'h30, 8'h0F);
        reg_read(A_MASK, v); check("R9 stray write", v, 8'hA5);
        reg_read(8'h16, v); check("R9 stray read", v, 8'h00);
        edges(3);
        check("R11 rdata held", rdata, 8'h00);
    endtask

    task automatic t_rise;
        logic [7:0] v;
        reg_write(A_MASK, 8'hFF);
        alarm[2] = 1;
        edges(1);
        check("R3 irq not yet", {7'd0, irq}, 8'h00);
        edges(1);
        check("R3 irq set", {7'd0, irq}, 8'h01);
        edges(4);
        check("R6 irq stays", {7'd0, irq}, 8'h01);
        reg_read(A_PEND, v); check("R3 pend rise", v, 8'h04);
        check("R6 irq drops", {7'd0, irq}, 8'h00);
        reg_read(A_PEND, v); check("R7 second read", v, 8'h00);
    endtask

    task automatic t_fall;
        logic [7:0] v;
        alarm[2] = 0;
        edges(2);
        check("R4 irq on fall", {7'd0, irq}, 8'h01);
        reg_read(A_PEND, v); check("R4 pend fall", v, 8'h04);
    endtask

    task automatic t_multi;
        logic [7:0] v;
        alarm[1] = 1; alarm[6] = 1;
        edges(3);
        reg_read(A_PEND, v); check("R10 two channels", v, 8'h42);
    endtask

    task automatic t_masked;
        logic [7:0] v;
        reg_write(A_MASK, 8'hF0);
        alarm[0] = 1;
        edges(3);
        check("R5 irq masked", {7'd0, irq}, 8'h00);
        reg_write(A_MASK, 8'hFF);
        edges(2);
        check("R5 irq after enable", {7'd0, irq}, 8'h00);
        reg_read(A_PEND, v); check("R5 pend masked", v, 8'h00);
    endtask

    task automatic t_coincident;
        logic [7:0] v;
        alarm[0] = 0;
        edges(3);
        alarm[3] = 1;
        edges(1);
        reg_read(A_PEND, v); check("R8 read old flags", v, 8'h01);
        check("R8 irq kept", {7'd0, irq}, 8'h01);
        reg_read(A_PEND, v); check("R8 new flag kept", v, 8'h08);
    endtask

    initial begin
        rst_n = 0; alarm = 0; addr = 0; wr = 0; rd = 0; wdata = 0;
        edges(3);
        rst_n = 1;
        edges(1);
        t_reset();
        t_mask_rw();
        t_ignored();
        t_rise();
        t_fall();
        t_multi();
        t_masked();
        t_coincident();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule